// File: doc/BRIEF.md
# Interrupt-Triggered Descriptor Transfer Engine

This block answers a peripheral interrupt request by moving a single byte or word through memory, so the processor does not have to run a software handler for each item. Every channel owns one descriptor: a control byte, a 16-bit I/O pointer, a 24-bit buffer pointer and a 16-bit item counter. Each channel also has an enable flag and a two-bit result code. When a request arrives on an enabled channel, the engine loads that descriptor. It checks whether the peripheral has asked to stop early, and otherwise reads one item from the source and writes it to the destination over a valid/ready memory port. It then steps the pointers and counts the item off.

While items remain, the engine pulses a clear back to the peripheral and no interrupt is seen. When the count runs out, when the peripheral stops the channel, or when the channel is not enabled, the request is passed to the processor as an ordinary interrupt. That interrupt stays up until the peripheral drops its request. The descriptors are loaded and inspected through a configuration port, one channel at a time.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset, busy_o, mem_req_o, req_clr_o and irq_o are all low, and every channel reads back with enable 0 and result 00.
- R2: A request on a channel whose enable is 0 causes no memory access. It raises irq_o for that channel, which stays high while req_i of that channel stays high and falls once the request is dropped.
- R3: If term_i of the serviced channel is high when its descriptor is loaded, and control bit 4 (stop-permit) is 1, then no memory access is made, the result becomes 11, enable is cleared, irq_o rises and the pointers and count are unchanged. With control bit 4 at 0, term_i has no effect.
- R4: Control bit 3 selects the direction. At 0 the engine reads at the I/O pointer (zero-extended to 24 bits) and writes at the buffer pointer. At 1 it reads at the buffer pointer and writes at the I/O pointer.
- R5: Control bit 0 at 1 holds the I/O pointer fixed, and control bit 1 at 1 holds the buffer pointer fixed. A pointer whose bit is 0 advances after each item.
- R6: Control bit 2 at 1 selects a 16-bit item (little-endian, pointer step 2, mem_word_o high). At 0 it selects a byte, moved on data bits 7:0 with pointer step 1; the neighbouring byte is untouched.
- R7: Each item decrements the count. If the count reaches 0, the result becomes 01, enable is cleared, irq_o rises and no request clear is given.
- R8: If the count is still non-zero, the result becomes 00, enable stays 1, irq_o stays low and req_clr_o pulses for exactly one cycle on that channel only.
- R9: A count of 0 loaded at start stands for 65536 items: the first item leaves the count at 0xFFFF with result 00.
- R10: When several eligible requests are present in the same cycle, the lowest-numbered channel is serviced first.
- R11: While busy_o is high no other request starts. A memory request holds its address and write flag stable until mem_ready_i, and each item costs exactly one read and one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Peripheral request, one level per channel |
| term_i | input | NCH | Peripheral stop request, one per channel |
| req_clr_o | output | NCH | One-cycle clear of the peripheral request |
| irq_o | output | NCH | Ordinary interrupt to the processor, per channel |
| busy_o | output | 1 | A service is in progress |
| cfg_we_i | input | 1 | Descriptor write strobe |
| cfg_ch_i | input | clog2(NCH) | Channel to write |
| cfg_ctrl_i | input | 8 | Control byte (bit0 I/O fixed, bit1 buffer fixed, bit2 word, bit3 direction, bit4 stop-permit) |
| cfg_ioa_i | input | 16 | I/O pointer |
| cfg_bap_i | input | 24 | Buffer pointer |
| cfg_cnt_i | input | 16 | Item count |
| cfg_en_i | input | 1 | Channel enable; the result is reset to 00 on a write |
| rd_ch_i | input | clog2(NCH) | Channel to read back |
| rd_ctrl_o | output | 8 | Control byte of rd_ch_i |
| rd_ioa_o | output | 16 | I/O pointer of rd_ch_i |
| rd_bap_o | output | 24 | Buffer pointer of rd_ch_i |
| rd_cnt_o | output | 16 | Count of rd_ch_i |
| rd_en_o | output | 1 | Enable of rd_ch_i |
| rd_res_o | output | 2 | Result code of rd_ch_i |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_word_o | output | 1 | 1 for a 16-bit access, 0 for a byte |
| mem_addr_o | output | 24 | Byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Completes the current access |

## Verification
A corrupted working register shows up in the memory at the wrong address or with the wrong width, and the descriptor read-back shows a wrong pointer step or count. All of this is visible within one service, about six cycles after the request. A wrong result or enable update is exposed at once by irq_o or req_clr_o: an interrupt with items still left, a missing clear, or a request that is serviced twice. A broken arbiter or a broken busy interlock shows as a second channel's count moving before the first service ends, or as more than two memory accesses per item.

// File: rtl/irq_xfer_pkg.sv
package irq_xfer_pkg;
  localparam int unsigned CTL_W    = 8;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned CTL_IOA_FIX = 0;
  localparam int unsigned CTL_BAP_FIX = 1;
  localparam int unsigned CTL_WORD    = 2;
  localparam int unsigned CTL_DIR     = 3;
  localparam int unsigned CTL_TERM    = 4;

  localparam logic [1:0] RES_MORE = 2'b00;
  localparam logic [1:0] RES_DONE = 2'b01;
  localparam logic [1:0] RES_TERM = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RD,
    ST_WR,
    ST_UPD
  } xfer_state_e;
endpackage

// File: rtl/irq_xfer_arb.sv
module irq_xfer_arb #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned CH_W = 2
) (
  input  logic [NCH-1:0]  req_i,
  output logic            any_o,
  output logic [CH_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CH_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_xfer_ptr_step.sv
module irq_xfer_ptr_step #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] ptr_i,
  input  logic         fixed_i,
  input  logic         word_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] step;
  assign step  = word_i ? W'(2) : W'(1);
  assign ptr_o = fixed_i ? ptr_i : ptr_i + step;
endmodule

// File: rtl/irq_xfer_desc_file.sv
module irq_xfer_desc_file #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CH_W  = 2,
  parameter int unsigned CTL_W = 8,
  parameter int unsigned IOA_W = 16,
  parameter int unsigned BAP_W = 24,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CH_W-1:0]  cfg_ch_i,
  input  logic [CTL_W-1:0] cfg_ctrl_i,
  input  logic [IOA_W-1:0] cfg_ioa_i,
  input  logic [BAP_W-1:0] cfg_bap_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  input  logic             cfg_en_i,
  input  logic             upd_we_i,
  input  logic [CH_W-1:0]  upd_ch_i,
  input  logic [IOA_W-1:0] upd_ioa_i,
  input  logic [BAP_W-1:0] upd_bap_i,
  input  logic [CNT_W-1:0] upd_cnt_i,
  input  logic [1:0]       upd_res_i,
  input  logic             upd_keep_en_i,
  input  logic [CH_W-1:0]  eng_ch_i,
  output logic [CTL_W-1:0] eng_ctrl_o,
  output logic [IOA_W-1:0] eng_ioa_o,
  output logic [BAP_W-1:0] eng_bap_o,
  output logic [CNT_W-1:0] eng_cnt_o,
  output logic [NCH-1:0]   en_vec_o,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic [CTL_W-1:0] rd_ctrl_o,
  output logic [IOA_W-1:0] rd_ioa_o,
  output logic [BAP_W-1:0] rd_bap_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             rd_en_o,
  output logic [1:0]       rd_res_o
);
  logic [CTL_W-1:0] ctrl_q [NCH];
  logic [IOA_W-1:0] ioa_q  [NCH];
  logic [BAP_W-1:0] bap_q  [NCH];
  logic [CNT_W-1:0] cnt_q  [NCH];
  logic [1:0]       res_q  [NCH];
  logic             en_q   [NCH];

  // engine write-back wins over a configuration write to the same channel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl_q[i] <= '0;
        ioa_q[i]  <= '0;
        bap_q[i]  <= '0;
        cnt_q[i]  <= '0;
        res_q[i]  <= '0;
        en_q[i]   <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (upd_we_i && upd_ch_i == CH_W'(i)) begin
          ioa_q[i] <= upd_ioa_i;
          bap_q[i] <= upd_bap_i;
          cnt_q[i] <= upd_cnt_i;
          res_q[i] <= upd_res_i;
          en_q[i]  <= en_q[i] & upd_keep_en_i;
        end else if (cfg_we_i && cfg_ch_i == CH_W'(i)) begin
          ctrl_q[i] <= cfg_ctrl_i;
          ioa_q[i]  <= cfg_ioa_i;
          bap_q[i]  <= cfg_bap_i;
          cnt_q[i]  <= cfg_cnt_i;
          res_q[i]  <= 2'b00;
          en_q[i]   <= cfg_en_i;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) en_vec_o[i] = en_q[i];
  end

  assign eng_ctrl_o = ctrl_q[eng_ch_i];
  assign eng_ioa_o  = ioa_q[eng_ch_i];
  assign eng_bap_o  = bap_q[eng_ch_i];
  assign eng_cnt_o  = cnt_q[eng_ch_i];

  assign rd_ctrl_o = ctrl_q[rd_ch_i];
  assign rd_ioa_o  = ioa_q[rd_ch_i];
  assign rd_bap_o  = bap_q[rd_ch_i];
  assign rd_cnt_o  = cnt_q[rd_ch_i];
  assign rd_en_o   = en_q[rd_ch_i];
  assign rd_res_o  = res_q[rd_ch_i];
endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine
  import irq_xfer_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned IOA_W = 16,
  parameter int unsigned BAP_W = 24,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH-1:0]    term_i,
  output logic [NCH-1:0]    req_clr_o,
  output logic [NCH-1:0]    irq_o,
  output logic              busy_o,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [CTL_W-1:0]  cfg_ctrl_i,
  input  logic [IOA_W-1:0]  cfg_ioa_i,
  input  logic [BAP_W-1:0]  cfg_bap_i,
  input  logic [CNT_W-1:0]  cfg_cnt_i,
  input  logic              cfg_en_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [CTL_W-1:0]  rd_ctrl_o,
  output logic [IOA_W-1:0]  rd_ioa_o,
  output logic [BAP_W-1:0]  rd_bap_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              rd_en_o,
  output logic [1:0]        rd_res_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_word_o,
  output logic [BAP_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  xfer_state_e       state_q;
  logic [CH_W-1:0]   ch_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [IOA_W-1:0]  ioa_q;
  logic [BAP_W-1:0]  bap_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              term_q;
  logic [NCH-1:0]    irq_pend_q;
  logic [NCH-1:0]    clr_q;

  logic [NCH-1:0]   eligible;
  logic             arb_any;
  logic [CH_W-1:0]  arb_idx;
  logic [NCH-1:0]   en_vec;
  logic [CTL_W-1:0] eng_ctrl;
  logic [IOA_W-1:0] eng_ioa;
  logic [BAP_W-1:0] eng_bap;
  logic [CNT_W-1:0] eng_cnt;
  logic [IOA_W-1:0] ioa_nxt;
  logic [BAP_W-1:0] bap_nxt;
  logic [CNT_W-1:0] cnt_dec;
  logic             cnt_last;
  logic [NCH-1:0]   ch_onehot;
  logic [NCH-1:0]   irq_set;
  logic             upd_we;
  logic [IOA_W-1:0] upd_ioa;
  logic [BAP_W-1:0] upd_bap;
  logic [CNT_W-1:0] upd_cnt;
  logic [1:0]       upd_res;
  logic             upd_keep_en;
  logic [BAP_W-1:0] ioa_ext;
  logic [BAP_W-1:0] src_addr;
  logic [BAP_W-1:0] dst_addr;
  logic             start_ok;
  logic             start_irq;

  // a pending interrupt or a clear in flight keeps a channel out of arbitration
  assign eligible = req_i & ~irq_pend_q & ~clr_q;

  irq_xfer_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .req_i (eligible),
    .any_o (arb_any),
    .idx_o (arb_idx)
  );

  irq_xfer_desc_file #(
    .NCH(NCH), .CH_W(CH_W), .CTL_W(CTL_W),
    .IOA_W(IOA_W), .BAP_W(BAP_W), .CNT_W(CNT_W)
  ) u_desc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_ch_i      (cfg_ch_i),
    .cfg_ctrl_i    (cfg_ctrl_i),
    .cfg_ioa_i     (cfg_ioa_i),
    .cfg_bap_i     (cfg_bap_i),
    .cfg_cnt_i     (cfg_cnt_i),
    .cfg_en_i      (cfg_en_i),
    .upd_we_i      (upd_we),
    .upd_ch_i      (ch_q),
    .upd_ioa_i     (upd_ioa),
    .upd_bap_i     (upd_bap),
    .upd_cnt_i     (upd_cnt),
    .upd_res_i     (upd_res),
    .upd_keep_en_i (upd_keep_en),
    .eng_ch_i      (ch_q),
    .eng_ctrl_o    (eng_ctrl),
    .eng_ioa_o     (eng_ioa),
    .eng_bap_o     (eng_bap),
    .eng_cnt_o     (eng_cnt),
    .en_vec_o      (en_vec),
    .rd_ch_i       (rd_ch_i),
    .rd_ctrl_o     (rd_ctrl_o),
    .rd_ioa_o      (rd_ioa_o),
    .rd_bap_o      (rd_bap_o),
    .rd_cnt_o      (rd_cnt_o),
    .rd_en_o       (rd_en_o),
    .rd_res_o      (rd_res_o)
  );

  irq_xfer_ptr_step #(.W(IOA_W)) u_ioa_step (
    .ptr_i   (ioa_q),
    .fixed_i (ctl_q[CTL_IOA_FIX]),
    .word_i  (ctl_q[CTL_WORD]),
    .ptr_o   (ioa_nxt)
  );

  irq_xfer_ptr_step #(.W(BAP_W)) u_bap_step (
    .ptr_i   (bap_q),
    .fixed_i (ctl_q[CTL_BAP_FIX]),
    .word_i  (ctl_q[CTL_WORD]),
    .ptr_o   (bap_nxt)
  );

  assign ch_onehot = NCH'(1) << ch_q;
  assign cnt_dec   = cnt_q - CNT_W'(1);
  assign cnt_last  = (cnt_dec == '0);
  assign start_ok  = (state_q == ST_IDLE) && arb_any && en_vec[arb_idx];
  assign start_irq = (state_q == ST_IDLE) && arb_any && !en_vec[arb_idx];

  always_comb begin
    upd_we      = (state_q == ST_UPD);
    upd_ioa     = ioa_q;
    upd_bap     = bap_q;
    upd_cnt     = cnt_q;
    upd_res     = RES_TERM;
    upd_keep_en = 1'b0;
    if (!term_q) begin
      upd_ioa     = ioa_nxt;
      upd_bap     = bap_nxt;
      upd_cnt     = cnt_dec;
      upd_res     = cnt_last ? RES_DONE : RES_MORE;
      upd_keep_en = !cnt_last;
    end
  end

  always_comb begin
    irq_set = '0;
    if (start_irq) irq_set = NCH'(1) << arb_idx;
    if (upd_we && !upd_keep_en) irq_set = irq_set | ch_onehot;
  end

  assign ioa_ext  = {{(BAP_W - IOA_W){1'b0}}, ioa_q};
  assign src_addr = ctl_q[CTL_DIR] ? bap_q : ioa_ext;
  assign dst_addr = ctl_q[CTL_DIR] ? ioa_ext : bap_q;

  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_word_o  = ctl_q[CTL_WORD];
  assign mem_addr_o  = (state_q == ST_WR) ? dst_addr : src_addr;
  assign mem_wdata_o = data_q;

  assign busy_o    = (state_q != ST_IDLE);
  assign irq_o     = irq_pend_q;
  assign req_clr_o = clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ch_q       <= '0;
      ctl_q      <= '0;
      ioa_q      <= '0;
      bap_q      <= '0;
      cnt_q      <= '0;
      data_q     <= '0;
      term_q     <= 1'b0;
      irq_pend_q <= '0;
      clr_q      <= '0;
    end else begin
      irq_pend_q <= (irq_pend_q & req_i) | irq_set;
      clr_q      <= (upd_we && upd_keep_en) ? ch_onehot : '0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            ch_q    <= arb_idx;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          ctl_q   <= eng_ctrl;
          ioa_q   <= eng_ioa;
          bap_q   <= eng_bap;
          cnt_q   <= eng_cnt;
          term_q  <= term_i[ch_q] & eng_ctrl[CTL_TERM];
          state_q <= (term_i[ch_q] & eng_ctrl[CTL_TERM]) ? ST_UPD : ST_RD;
        end
        ST_RD: begin
          if (mem_ready_i) begin
            data_q  <= ctl_q[CTL_WORD] ? mem_rdata_i : {8'h00, mem_rdata_i[7:0]};
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_ready_i) state_q <= ST_UPD;
        end
        ST_UPD: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_xfer_chk.sv
module irq_xfer_chk #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned AW   = 24
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] req_i,
  input logic [NCH-1:0] req_clr_o,
  input logic [NCH-1:0] irq_o,
  input logic           busy_o,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           mem_ready_i
);
  assert_clr_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_clr_o));

  assert_clr_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_clr_o) |=> !(|req_clr_o));

  assert_mem_only_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_mem_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  for (genvar g = 0; g < NCH; g++) begin : g_irq
    assert_irq_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[g] && req_i[g]) |=> irq_o[g]);
    assert_irq_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[g] && !req_i[g] && !busy_o) |=> !irq_o[g]);
  end
endmodule

bind irq_xfer_engine irq_xfer_chk #(.NCH(NCH), .AW(BAP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .req_clr_o   (req_clr_o),
  .irq_o       (irq_o),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/tb_irq_xfer_engine.sv
module tb_irq_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  preq;
  logic [3:0]  term_r = '0;
  logic [3:0]  req_clr;
  logic [3:0]  irq;
  logic        busy;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [7:0]  cfg_ctrl = '0;
  logic [15:0] cfg_ioa = '0;
  logic [23:0] cfg_bap = '0;
  logic [15:0] cfg_cnt = '0;
  logic        cfg_en = 1'b0;
  logic [1:0]  rd_ch = '0;
  logic [7:0]  rd_ctrl;
  logic [15:0] rd_ioa;
  logic [23:0] rd_bap;
  logic [15:0] rd_cnt;
  logic        rd_en;
  logic [1:0]  rd_res;
  logic        mem_req, mem_we, mem_word;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_rdy;

  logic [3:0]  sw_raise = '0;
  logic [3:0]  sw_drop = '0;
  logic        pl_we = 1'b0;
  logic [9:0]  pl_addr = '0;
  logic [7:0]  pl_data = '0;
  logic [7:0]  mem_b [1024];
  int          acc_cnt;
  int          clr_cnt [4];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_xfer_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(preq), .term_i(term_r),
    .req_clr_o(req_clr), .irq_o(irq), .busy_o(busy),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_ctrl_i(cfg_ctrl), .cfg_ioa_i(cfg_ioa),
    .cfg_bap_i(cfg_bap), .cfg_cnt_i(cfg_cnt), .cfg_en_i(cfg_en),
    .rd_ch_i(rd_ch), .rd_ctrl_o(rd_ctrl), .rd_ioa_o(rd_ioa), .rd_bap_o(rd_bap),
    .rd_cnt_o(rd_cnt), .rd_en_o(rd_en), .rd_res_o(rd_res),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_word_o(mem_word), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_rdy)
  );

  assign mem_rdata = {mem_b[mem_addr[9:0] + 10'd1], mem_b[mem_addr[9:0]]};

  // memory with one wait state, and peripheral request flops
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rdy <= 1'b0;
      preq    <= '0;
      acc_cnt <= 0;
      for (int i = 0; i < 4; i++) clr_cnt[i] <= 0;
    end else begin
      mem_rdy <= mem_req && !mem_rdy;
      if (mem_req && mem_rdy) begin
        acc_cnt <= acc_cnt + 1;
        if (mem_we) begin
          mem_b[mem_addr[9:0]] <= mem_wdata[7:0];
          if (mem_word) mem_b[mem_addr[9:0] + 10'd1] <= mem_wdata[15:8];
        end
      end
      if (pl_we) mem_b[pl_addr] <= pl_data;
      for (int i = 0; i < 4; i++) begin
        if (req_clr[i]) clr_cnt[i] <= clr_cnt[i] + 1;
        if (sw_raise[i]) preq[i] <= 1'b1;
        else if (req_clr[i] || sw_drop[i]) preq[i] <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input logic [7:0] ctl, input logic [15:0] ioa,
                     input logic [23:0] bap, input logic [15:0] cnt, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_ctrl = ctl; cfg_ioa = ioa;
    cfg_bap = bap; cfg_cnt = cnt; cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic preload(input int addr, input logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = 10'(addr); pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic raise(input logic [3:0] m);
    @(negedge clk);
    sw_raise = m;
    @(negedge clk);
    sw_raise = '0;
  endtask

  task automatic drop(input logic [3:0] m);
    @(negedge clk);
    sw_drop = m;
    @(negedge clk);
    sw_drop = '0;
    @(negedge clk);
  endtask

  task automatic wait_service;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic sel(input int ch);
    rd_ch = 2'(ch);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 req_clr", 32'(req_clr), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    sel(2);
    chk("R1 en", 32'(rd_en), 0);
    chk("R1 res", 32'(rd_res), 0);
  endtask

  task automatic t_disabled;
    int a0;
    cfg(1, 8'h00, 16'h0060, 24'h000260, 16'd3, 1'b0);
    a0 = acc_cnt;
    raise(4'b0010);
    repeat (3) @(negedge clk);
    chk("R2 irq raised", 32'(irq[1]), 1);
    chk("R2 no access", 32'(acc_cnt - a0), 0);
    chk("R2 not busy", 32'(busy), 0);
    repeat (4) @(negedge clk);
    chk("R2 irq held", 32'(irq[1]), 1);
    drop(4'b0010);
    chk("R2 irq falls", 32'(irq[1]), 0);
  endtask

  task automatic t_byte_in;
    int a0, c0;
    preload(16'h40, 8'hA5); preload(16'h41, 8'h77);
    preload(16'h200, 8'h11); preload(16'h201, 8'h11);
    cfg(0, 8'h00, 16'h0040, 24'h000200, 16'd3, 1'b1);
    a0 = acc_cnt; c0 = clr_cnt[0];
    raise(4'b0001);
    wait_service();
    @(negedge clk);
    chk("R4 dir0 dest byte", 32'(mem_b[10'h200]), 32'hA5);
    chk("R6 byte neighbour", 32'(mem_b[10'h201]), 32'h11);
    sel(0);
    chk("R5 ioa advance", 32'(rd_ioa), 32'h41);
    chk("R5 bap advance", 32'(rd_bap), 32'h201);
    chk("R7 cnt dec", 32'(rd_cnt), 2);
    chk("R8 res", 32'(rd_res), 0);
    chk("R8 en kept", 32'(rd_en), 1);
    chk("R8 no irq", 32'(irq[0]), 0);
    chk("R8 one clear", 32'(clr_cnt[0] - c0), 1);
    chk("R8 req dropped", 32'(preq[0]), 0);
    chk("R11 two accesses", 32'(acc_cnt - a0), 2);
  endtask

  task automatic t_word_out;
    preload(16'h300, 8'h34); preload(16'h301, 8'h12);
    preload(16'h80, 8'h00); preload(16'h81, 8'h00);
    cfg(2, 8'h0D, 16'h0080, 24'h000300, 16'd5, 1'b1);
    raise(4'b0100);
    wait_service();
    @(negedge clk);
    chk("R4 dir1 low", 32'(mem_b[10'h080]), 32'h34);
    chk("R6 word high", 32'(mem_b[10'h081]), 32'h12);
    sel(2);
    chk("R5 ioa fixed", 32'(rd_ioa), 32'h80);
    chk("R6 bap step 2", 32'(rd_bap), 32'h302);
    chk("R7 cnt 4", 32'(rd_cnt), 4);
  endtask

  task automatic t_bap_fixed;
    preload(16'h50, 8'h5C);
    cfg(3, 8'h02, 16'h0050, 24'h000220, 16'd9, 1'b1);
    raise(4'b1000);
    wait_service();
    @(negedge clk);
    chk("R5 bap fixed data", 32'(mem_b[10'h220]), 32'h5C);
    sel(3);
    chk("R5 bap fixed", 32'(rd_bap), 32'h220);
    chk("R5 ioa step 1", 32'(rd_ioa), 32'h51);
  endtask

  task automatic t_last;
    int c0;
    preload(16'h44, 8'h9E);
    cfg(0, 8'h00, 16'h0044, 24'h000240, 16'd1, 1'b1);
    c0 = clr_cnt[0];
    raise(4'b0001);
    wait_service();
    chk("R7 irq at end", 32'(irq[0]), 1);
    @(negedge clk);
    sel(0);
    chk("R7 data", 32'(mem_b[10'h240]), 32'h9E);
    chk("R7 res done", 32'(rd_res), 1);
    chk("R7 en cleared", 32'(rd_en), 0);
    chk("R7 cnt zero", 32'(rd_cnt), 0);
    chk("R7 no clear", 32'(clr_cnt[0] - c0), 0);
    drop(4'b0001);
    chk("R7 irq falls", 32'(irq[0]), 0);
  endtask

  task automatic t_term;
    int a0;
    cfg(1, 8'h10, 16'h0070, 24'h000270, 16'd4, 1'b1);
    term_r = 4'b0010;
    a0 = acc_cnt;
    raise(4'b0010);
    wait_service();
    @(negedge clk);
    sel(1);
    chk("R3 no access", 32'(acc_cnt - a0), 0);
    chk("R3 res term", 32'(rd_res), 3);
    chk("R3 en cleared", 32'(rd_en), 0);
    chk("R3 irq", 32'(irq[1]), 1);
    chk("R3 cnt kept", 32'(rd_cnt), 4);
    chk("R3 ioa kept", 32'(rd_ioa), 32'h70);
    drop(4'b0010);
    term_r = '0;
  endtask

  task automatic t_term_off;
    int a0;
    cfg(1, 8'h00, 16'h0072, 24'h000272, 16'd4, 1'b1);
    term_r = 4'b0010;
    a0 = acc_cnt;
    raise(4'b0010);
    wait_service();
    @(negedge clk);
    sel(1);
    chk("R3 ignored accesses", 32'(acc_cnt - a0), 2);
    chk("R3 ignored res", 32'(rd_res), 0);
    chk("R3 ignored cnt", 32'(rd_cnt), 3);
    term_r = '0;
  endtask

  task automatic t_zero_cnt;
    cfg(3, 8'h00, 16'h0058, 24'h000280, 16'd0, 1'b1);
    raise(4'b1000);
    wait_service();
    @(negedge clk);
    sel(3);
    chk("R9 cnt wraps", 32'(rd_cnt), 32'hFFFF);
    chk("R9 res more", 32'(rd_res), 0);
    chk("R9 en kept", 32'(rd_en), 1);
  endtask

  task automatic t_priority;
    int a0;
    cfg(2, 8'h00, 16'h0090, 24'h000290, 16'd5, 1'b1);
    cfg(3, 8'h00, 16'h0098, 24'h000298, 16'd5, 1'b1);
    a0 = acc_cnt;
    raise(4'b1100);
    wait_service();
    sel(2);
    chk("R10 low channel first", 32'(rd_cnt), 4);
    sel(3);
    chk("R11 high channel waits", 32'(rd_cnt), 5);
    chk("R11 accesses first", 32'(acc_cnt - a0), 2);
    wait_service();
    @(negedge clk);
    sel(3);
    chk("R10 high channel next", 32'(rd_cnt), 4);
    chk("R11 accesses both", 32'(acc_cnt - a0), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_byte_in();
    t_word_out();
    t_bap_fixed();
    t_last();
    t_term();
    t_term_off();
    t_zero_cnt();
    t_priority();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule